// File: doc/BRIEF.md
# Cascadable Serial Configuration Data Streamer

This block holds a small on-chip array of configuration words. It plays them out to a downstream device that is being configured. In serial mode it sends one bit per clock on a single line, taking the most significant bit of each word first. In parallel mode it sends one whole byte per clock on eight lines. An internal position counter walks through the array. The counter moves only on clock edges where the streamer is selected and not held in reset. A hold/reset input sends the counter back to the first bit, so every new configuration attempt starts at the beginning of the stream.

Several streamers can form a chain. Each streamer drives a cascade-enable output into the select input of the next one. Once its last word has been sent, a streamer stops driving the data lines and hands the bus to its neighbour. A separate request input makes the streamer drive an active-low reconfigure-request line low for a fixed number of cycles. The array is filled through a plain synchronous write port.

Top module: `cfg_streamer`

## Requirements
- R1: While rstN is low, ceoN and reconfReqN read 1, and the position is returned to the first bit of word 0.
- R2: The position advances by one unit on a rising clock edge only while ceN is 0 and holdRst is 0. While ceN is 1, the position is kept unchanged.
- R3: When holdRst is 1 at a rising edge, the position returns to bit 0 of word 0. While holdRst is 1, dataDrive is 0.
- R4: When parMode is 0 (serial), dataOut[0] carries bit (7 - k) of the current word at bit step k, so each word goes out MSB first, and dataOut[7:1] read 0. A new bit appears after each advancing edge.
- R5: When parMode is 1 (parallel), dataOut[7:0] carries the whole current word, and a new word appears after each advancing edge.
- R6: dataDrive is 1 exactly when ceN is 0, holdRst is 0, and the stream has not ended. It is 0 whenever ceN is 1.
- R7: The stream ends at the edge that consumes the last unit of word DEPTH-1. From then on, dataDrive is 0, ceoN is 0 while ceN is 0, and the position stays frozen until holdRst is applied.
- R8: ceoN reads 1 whenever ceN is 1.
- R9: When cfgPulse is 1 at a rising edge while reconfReqN is 1, reconfReqN reads 0 from that edge for exactly PULSE_LEN cycles. A cfgPulse that arrives while reconfReqN is 0 is ignored.
- R10: When wrEn is 1 at a rising edge, wrData is stored at word wrAddr and is played out in the next stream.
- R11: When a second streamer's ceN is driven by the first streamer's ceoN, exactly one of the two drives the data lines while the chain is active. The second streamer's words follow the first streamer's words with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock; the position advances on rising edges |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low select; the stream runs only while it is 0 |
| holdRst | input | 1 | Active-high hold: floats the outputs and rewinds the position |
| parMode | input | 1 | 0 = serial (one bit per clock), 1 = parallel (one byte per clock) |
| wrEn | input | 1 | Write strobe for the word array |
| wrAddr | input | $clog2(DEPTH) | Word index to write |
| wrData | input | 8 | Word to write |
| cfgPulse | input | 1 | Request to start a reconfigure-request pulse |
| dataOut | output | 8 | Stream data; only bit 0 is used in serial mode |
| dataDrive | output | 1 | Pad enable for dataOut; 0 means the lines float |
| ceoN | output | 1 | Active-low cascade enable for the next streamer |
| reconfReqN | output | 1 | Active-low reconfigure request, held low for PULSE_LEN cycles |

## Verification
Four stored patterns are streamed. Two run in serial mode and two in parallel mode. The serial words (A5, 3C, FF, 00, 80, 01, 7E, 81) have alternating bits, all-ones, all-zeros and single set bits at either end, so a reversed bit order or a wrong bit index shows up as a mismatch. The parallel words (12, 34, 56, 78, FF, 00, AA, 55) reveal swapped lanes, a skipped word and a stuck address bit. Directed cases cover these situations:
- deselecting the streamer mid-word, which separates a stalled position from one that keeps counting;
- a hold in mid-stream, which must rewind to the first bit;
- clocking on after the end of the stream, which must stay frozen;
- a second request during the reconfigure pulse;
- a two-streamer chain, where an off-by-one handoff would show as a gap or an overlap.

// File: rtl/cfg_streamer_pkg.sv
package cfg_streamer_pkg;
  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic clear;     // rewind to bit 0 of word 0
    logic stepBit;   // next bit inside the current word (serial)
    logic stepWord;  // next word
  } cfgStrobeT;
endpackage

// File: rtl/cfg_streamer_datapath.sv
module cfg_streamer_datapath
  import cfg_streamer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobeT        stb,
  input  logic             parMode,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] dataOut,
  output logic             bitLast,
  output logic             addrLast
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WIDTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    addr;
  logic [BW-1:0]    bitIdx;
  logic [WIDTH-1:0] curWord;
  logic             serBit;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      bitIdx <= '0;
    end else if (stb.clear) begin
      addr   <= '0;
      bitIdx <= '0;
    end else if (stb.stepWord) begin
      addr   <= addr + AW'(1);
      bitIdx <= '0;
    end else if (stb.stepBit) begin
      bitIdx <= bitIdx + BW'(1);
    end
  end

  assign curWord  = mem[addr];
  assign serBit   = curWord[LAST_BIT - bitIdx];
  assign bitLast  = (bitIdx == LAST_BIT);
  assign addrLast = (addr == LAST_ADDR);

  // Lane 0 carries either the serial bit or word bit 0; the rest are parallel only
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    if (g == 0) begin : g_shared
      assign dataOut[g] = parMode ? curWord[g] : serBit;
    end else begin : g_parOnly
      assign dataOut[g] = parMode & curWord[g];
    end
  end

  // R3: a clear strobe rewinds to the stream start
  p_clear_rewinds_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (addr == '0 && bitIdx == '0));
  // R2: no strobe, no movement
  p_hold_position_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && !stb.stepBit && !stb.stepWord) |=> ($stable(addr) && $stable(bitIdx)));
  // R5: a word step moves to the following word
  p_word_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepWord && !stb.clear && !addrLast) |=> (addr == $past(addr) + AW'(1)));
endmodule

// File: rtl/cfg_streamer_ctrl.sv
module cfg_streamer_ctrl
  import cfg_streamer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      holdRst,
  input  logic      parMode,
  input  logic      bitLast,
  input  logic      addrLast,
  output cfgStrobeT stb,
  output logic      driveEn,
  output logic      ceoN
);
  logic ended;
  logic run;
  logic unitEndsWord;

  assign run          = !ceN && !holdRst && !ended;
  assign unitEndsWord = parMode || bitLast;

  always_comb begin
    stb          = '0;
    stb.clear    = holdRst;
    stb.stepWord = run && unitEndsWord;
    stb.stepBit  = run && !unitEndsWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         ended <= 1'b0;
    else if (holdRst)                  ended <= 1'b0;
    else if (stb.stepWord && addrLast) ended <= 1'b1;
  end

  assign driveEn = run;
  assign ceoN    = !(ended && !ceN);

  // R7: once handed off, this streamer releases the lines
  p_float_after_handoff_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ceoN |-> !driveEn);
  // R7: no stepping after the stream ended
  p_frozen_after_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    ended |-> (!stb.stepBit && !stb.stepWord));
  // R7: the last word step ends the stream
  p_end_on_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepWord && addrLast && !holdRst) |=> (ended && (ceoN == ceN)));
endmodule

// File: rtl/cfg_streamer_reconf.sv
module cfg_streamer_reconf #(
  parameter int PULSE_LEN = 8,
  localparam int CW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgPulse,
  output logic reconfReqN
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          remain <= '0;
    else if (remain != '0)              remain <= remain - CW'(1);
    else if (cfgPulse)                  remain <= CW'(PULSE_LEN);
  end

  assign reconfReqN = (remain == '0);

  // R9: the window counts down one per cycle, ignoring new requests
  p_window_countdown_r9: assert property (@(posedge clk) disable iff (!rstN)
    (remain != '0) |=> (remain == $past(remain) - CW'(1)));
  // R9: the request line only falls after a request
  p_fall_needs_request_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reconfReqN) |-> $past(cfgPulse));
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_streamer_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PULSE_LEN = 8,
  localparam int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             holdRst,
  input  logic             parMode,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             cfgPulse,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataDrive,
  output logic             ceoN,
  output logic             reconfReqN
);
  cfgStrobeT stb;
  logic      bitLast;
  logic      addrLast;

  cfg_streamer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .holdRst  (holdRst),
    .parMode  (parMode),
    .bitLast  (bitLast),
    .addrLast (addrLast),
    .stb      (stb),
    .driveEn  (dataDrive),
    .ceoN     (ceoN)
  );

  cfg_streamer_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .parMode  (parMode),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .dataOut  (dataOut),
    .bitLast  (bitLast),
    .addrLast (addrLast)
  );

  cfg_streamer_reconf #(.PULSE_LEN(PULSE_LEN)) u_reconf (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPulse   (cfgPulse),
    .reconfReqN (reconfReqN)
  );

  // R8: a deselected streamer never enables its neighbour
  p_ceo_idle_when_deselected_r8: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> ceoN);
endmodule

// File: tb/sim_cfg_streamer.sv
module sim_cfg_streamer;
  localparam int DEPTH = 4;
  localparam int PLEN  = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, ceN0, holdRst, parMode, wrEn0, wrEn1, cfgPulse, noPulse;
  logic [1:0] wrAddr;
  logic [7:0] wrData, data0, data1;
  logic       drv0, drv1, ceo0, ceo1, rq0, rq1;

  int nChk  = 0;
  int nFail = 0;

  // bit 32 = parMode, words w0..w3 from the top byte down
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 32'hA53CFF00},
    {1'b1, 32'h12345678},
    {1'b0, 32'h80017E81},
    {1'b1, 32'hFF00AA55}
  };

  cfg_streamer #(.DEPTH(DEPTH), .PULSE_LEN(PLEN)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN0), .holdRst(holdRst), .parMode(parMode),
    .wrEn(wrEn0), .wrAddr(wrAddr), .wrData(wrData), .cfgPulse(cfgPulse),
    .dataOut(data0), .dataDrive(drv0), .ceoN(ceo0), .reconfReqN(rq0));

  cfg_streamer #(.DEPTH(DEPTH), .PULSE_LEN(PLEN)) u1 (
    .clk(clk), .rstN(rstN), .ceN(ceo0), .holdRst(holdRst), .parMode(parMode),
    .wrEn(wrEn1), .wrAddr(wrAddr), .wrData(wrData), .cfgPulse(noPulse),
    .dataOut(data1), .dataDrive(drv1), .ceoN(ceo1), .reconfReqN(rq1));

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] wordOf(input logic [31:0] ws, input int i);
    return ws[(3 - i) * 8 +: 8];
  endfunction

  task automatic loadWords(input logic [31:0] ws, input int sel);
    for (int i = 0; i < DEPTH; i++) begin
      wrAddr = 2'(i); wrData = wordOf(ws, i);
      wrEn0 = (sel == 0); wrEn1 = (sel == 1);
      tick();
    end
    wrEn0 = 1'b0; wrEn1 = 1'b0;
  endtask

  task automatic rewind();
    holdRst = 1'b1; ceN0 = 1'b0; tick(); holdRst = 1'b0; #1;
  endtask

  task automatic streamCheck(input logic [31:0] ws, input logic par, input string tag);
    parMode = par;
    rewind();
    for (int k = 0; k < (par ? DEPTH : DEPTH * 8); k++) begin
      logic [7:0] w;
      logic [7:0] exp;
      w   = wordOf(ws, par ? k : k / 8);
      exp = par ? w : {7'b0, w[7 - (k % 8)]};
      chk(tag, data0, exp);
      chk("R6 drive while streaming", drv0, 1);
      tick(); #1;
    end
    chk("R7 ceoN low at end", ceo0, 0);
    chk("R7 float at end", drv0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] ws;
    rstN = 1'b0; ceN0 = 1'b1; holdRst = 1'b0; parMode = 1'b0;
    wrEn0 = 1'b0; wrEn1 = 1'b0; wrAddr = '0; wrData = '0;
    cfgPulse = 1'b0; noPulse = 1'b0;
    #11;
    chk("R1 ceoN in reset", ceo0, 1);
    chk("R1 reconfReqN in reset", rq0, 1);
    chk("R6 no drive when deselected", drv0, 0);
    rstN = 1'b1;
    tick();

    // R1: first stream after reset starts at bit 0 of word 0 without a hold
    loadWords(VEC[0][31:0], 0);
    ceN0 = 1'b0; #1;
    chk("R1 start at word 0 bit 7", data0, {7'b0, VEC[0][31]});
    ceN0 = 1'b1;

    // Table walk: R4 serial, R5 parallel, R10 contents via the write port
    for (int v = 0; v < 4; v++) begin
      loadWords(VEC[v][31:0], 0);
      streamCheck(VEC[v][31:0], VEC[v][32], VEC[v][32] ? "R5 parallel word" : "R4 serial bit");
    end

    // R7: clocking on after the end keeps everything frozen
    tick(); tick(); tick(); #1;
    chk("R7 ceoN stays low", ceo0, 0);
    chk("R7 stays floating", drv0, 0);
    ceN0 = 1'b1; #1;
    chk("R8 ceoN high when deselected", ceo0, 1);
    ceN0 = 1'b0; #1;
    chk("R7 still ended", ceo0, 0);

    // R2: stall mid-word while deselected
    ws = VEC[0][31:0];
    loadWords(ws, 0);
    parMode = 1'b0;
    rewind();
    tick(); tick(); tick();
    ceN0 = 1'b1;
    tick(); tick(); tick(); #1;
    chk("R6 float while deselected", drv0, 0);
    chk("R8 ceoN while deselected", ceo0, 1);
    ceN0 = 1'b0; #1;
    chk("R2 position held at bit 3", data0, {7'b0, ws[31 - 3]});
    tick(); tick();
    holdRst = 1'b1; #1;
    chk("R3 float during hold", drv0, 0);
    tick(); holdRst = 1'b0; #1;
    chk("R3 rewound to first bit", data0, {7'b0, ws[31]});
    chk("R3 drives after hold", drv0, 1);

    // R10: rewrite a single word and replay
    wrAddr = 2'd2; wrData = 8'hC3; wrEn0 = 1'b1; tick(); wrEn0 = 1'b0;
    ws = VEC[1][31:0];
    loadWords(ws, 0);
    wrAddr = 2'd2; wrData = 8'hC3; wrEn0 = 1'b1; tick(); wrEn0 = 1'b0;
    ws[15:8] = 8'hC3;
    streamCheck(ws, 1'b1, "R10 rewritten word");

    // R9: reconfigure pulse, second request inside the window ignored
    ceN0 = 1'b1;
    cfgPulse = 1'b1; tick(); cfgPulse = 1'b0; #1;
    for (int i = 0; i < PLEN; i++) begin
      chk("R9 request low", rq0, 0);
      if (i == 2) cfgPulse = 1'b1;
      tick();
      cfgPulse = 1'b0; #1;
    end
    chk("R9 request released", rq0, 1);
    tick(); #1;
    chk("R9 late request ignored", rq0, 1);

    // R11: two-streamer chain in parallel mode
    loadWords(VEC[1][31:0], 0);
    loadWords(VEC[3][31:0], 1);
    parMode = 1'b1;
    rewind();
    for (int k = 0; k < 2 * DEPTH; k++) begin
      logic [7:0] exp;
      exp = (k < DEPTH) ? wordOf(VEC[1][31:0], k) : wordOf(VEC[3][31:0], k - DEPTH);
      chk("R11 single driver", int'(drv0) + int'(drv1), 1);
      chk("R11 chained word", drv0 ? data0 : data1, exp);
      tick(); #1;
    end
    chk("R11 chain ended", ceo1, 0);
    chk("R11 chain floats", int'(drv0) + int'(drv1), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule